// File: doc/BRIEF.md
# Endian-Aware Bus Width Splitter

This block sits between a 64-bit internal memory request port and an external SDRAM data path whose width is chosen per channel. When the channel is configured wide, a request goes out unchanged as a single external beat. When the channel is configured narrow, every request becomes exactly two half-width beats on the low data lanes. The order of the two words follows an endian-mode input, and the upper mask lanes stay parked in the inactive state.

For reads, each returned half-width beat is steered back into the internal half it belongs to. The assembled 64-bit word is presented together with the single request acknowledge. Command sequencing, addressing and refresh belong to the SDRAM core. Here that core is reduced to a per-beat request/acknowledge pair. Width and endian settings are captured when a request is accepted and stay fixed until it completes.

Top module: `bus_width_splitter`

## Requirements
- R1: In wide mode (`cfg_narrow`=0) a request produces exactly one external beat. `ext_dq_out` equals the full write word, and `ext_dqm` equals the bitwise inverse of `req_be`, where a mask bit of 1 disables its byte.
- R2: In narrow mode (`cfg_narrow`=1) a request always produces exactly two external beats, even when `req_be` selects only bytes of one half.
- R3: In narrow mode, every beat drives `ext_dqm[7:4]` to 4'hF. `ext_dqm[3:0]` is the inverse of the byte-enable half that belongs to the word being transferred: `req_be[7:4]` for the upper word, `req_be[3:0]` for the lower word.
- R4: During a read beat both output enables `ext_dq_oe_lo` and `ext_dq_oe_hi` are 0, so the lanes are released. During a write beat both are 1.
- R5: In narrow big-endian mode (`cfg_big_endian`=1), the first beat carries internal bits 63:32 on `ext_dq_out[31:0]` and the second beat carries bits 31:0.
- R6: In narrow little-endian mode (`cfg_big_endian`=0), the first beat carries internal bits 31:0 and the second beat carries bits 63:32.
- R7: `req_ack` is a one-cycle pulse. It is asserted in the cycle after the edge at which the final beat's `ext_ack` is seen, and `ext_req` is 0 while it is high.
- R8: For reads, `rd_valid` is high only together with `req_ack`. In narrow mode, `ext_dq_in[31:0]` of each beat lands in the internal half that the beat addresses, and `ext_dq_in[63:32]` is ignored. In wide mode `rd_data` equals the returned 64-bit word. For writes `rd_valid` stays 0.
- R9: `cfg_narrow` and `cfg_big_endian` are sampled when a request is accepted. Changing them while the request is in flight does not affect its beat count or order.
- R10: After reset and while idle, `ext_req`, `req_ack`, `rd_valid` and both output enables are 0, and `ext_dqm` is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Internal request, held until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Internal write word |
| req_be | input | 8 | Internal byte enables, active high |
| cfg_narrow | input | 1 | 1 = 32-bit external bus, 0 = 64-bit |
| cfg_big_endian | input | 1 | 1 = upper word first in narrow mode |
| req_ack | output | 1 | Request complete pulse |
| rd_data | output | 64 | Assembled read word |
| rd_valid | output | 1 | Read word valid, with `req_ack` |
| ext_req | output | 1 | External beat request |
| ext_write | output | 1 | Beat direction toward the core |
| ext_dq_out | output | 64 | External write lanes |
| ext_dq_oe_lo | output | 1 | Output enable, lanes 31:0 |
| ext_dq_oe_hi | output | 1 | Output enable, lanes 63:32 |
| ext_dqm | output | 8 | Byte masks, 1 = byte disabled |
| ext_dq_in | input | 64 | External read lanes |
| ext_ack | input | 1 | Core completes the current beat |

## Verification
The bench builds the block with its default `DATA_W` of 64, which gives two 32-bit halves and an 8-bit byte-enable field. Every listed lane and mask position is therefore directly observable. At this width a half-sized enable field such as 8'h0F shows that the second narrow beat is still issued with all of its masks inactive. Garbage placed on the upper read lanes during narrow reads shows that those lanes are ignored. The core model can stretch each beat by several cycles, which exercises the acknowledge timing, and the configuration inputs can be flipped mid-request to exercise sampling at acceptance.

// File: rtl/bws_pkg.sv
`timescale 1ns/1ps
package bws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT0 = 2'd1,
    ST_BEAT1 = 2'd2,
    ST_DONE  = 2'd3
  } bws_state_e;

  // Which internal half (0 = low, 1 = high) a narrow beat carries.
  function automatic logic beat_half(input logic second_beat, input logic big_endian);
    return second_beat ^ big_endian;
  endfunction

  // Number of external beats one internal request needs.
  function automatic logic [1:0] beats_needed(input logic narrow);
    return narrow ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/bws_seq.sv
`timescale 1ns/1ps
module bws_seq
  import bws_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic cfg_narrow,
  input  logic cfg_big_endian,
  input  logic ext_ack,
  output logic accept,
  output logic ext_req,
  output logic beat_fire,
  output logic last_fire,
  output logic cur_write,
  output logic cur_narrow,
  output logic cur_half,
  output logic req_ack
);

  bws_state_e state_q, state_d;
  logic       cur_big;
  logic [1:0] beat_cnt_q;
  logic       second_beat;

  assign accept      = (state_q == ST_IDLE) && req_valid;
  assign ext_req     = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
  assign second_beat = (state_q == ST_BEAT1);
  assign beat_fire   = ext_req && ext_ack;
  assign last_fire   = beat_fire && (!cur_narrow || second_beat);
  assign cur_half    = beat_half(second_beat, cur_big);
  assign req_ack     = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_BEAT0;
      ST_BEAT0: if (beat_fire) state_d = cur_narrow ? ST_BEAT1 : ST_DONE;
      ST_BEAT1: if (beat_fire) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_write  <= 1'b0;
      cur_narrow <= 1'b0;
      cur_big    <= 1'b0;
      beat_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cur_write  <= req_write;
        cur_narrow <= cfg_narrow;
        cur_big    <= cfg_big_endian;
        beat_cnt_q <= '0;
      end else if (beat_fire) begin
        beat_cnt_q <= beat_cnt_q + 2'd1;
      end
    end
  end

  AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (beat_cnt_q == beats_needed(cur_narrow))); // R2
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack); // R7
  AST_ACK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> $past(last_fire)); // R7
  AST_ACK_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !ext_req); // R7
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && $past(ext_req)) |-> ($stable(cur_narrow) && $stable(cur_big))); // R9

endmodule

// File: rtl/bws_lane_mux.sv
`timescale 1ns/1ps
module bws_lane_mux #(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                write,
  input  logic                narrow,
  input  logic                half,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] be,
  output logic [DATA_W-1:0]   dq_out,
  output logic [DATA_W/8-1:0] dqm,
  output logic                oe_lo,
  output logic                oe_hi
);

  localparam int HALF_W  = DATA_W / 2;
  localparam int BE_W    = DATA_W / 8;
  localparam int HALF_BE = BE_W / 2;

  logic [HALF_W-1:0]  sel_word;
  logic [HALF_BE-1:0] sel_be;

  assign sel_word = half ? wdata[DATA_W-1:HALF_W] : wdata[HALF_W-1:0];
  assign sel_be   = half ? be[BE_W-1:HALF_BE]     : be[HALF_BE-1:0];

  always_comb begin
    dq_out = '0;
    dqm    = '1;
    if (active) begin
      if (narrow) begin
        dq_out = {sel_word, sel_word};
        dqm    = {{HALF_BE{1'b1}}, ~sel_be};
      end else begin
        dq_out = wdata;
        dqm    = ~be;
      end
    end
  end

  assign oe_lo = active && write;
  assign oe_hi = active && write;

  AST_NARROW_UPPER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (active && narrow) |-> (&dqm[BE_W-1:HALF_BE])); // R3
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !write) |-> (!oe_lo && !oe_hi)); // R4
  AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> ((&dqm) && !oe_lo && !oe_hi)); // R10

endmodule

// File: rtl/bws_rd_asm.sv
`timescale 1ns/1ps
module bws_rd_asm #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              beat_fire,
  input  logic              write,
  input  logic              narrow,
  input  logic              half,
  input  logic              done,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int HALF_W = DATA_W / 2;
  localparam int NHALF  = 2;

  logic [NHALF-1:0] filled;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W-1:0] word_q;
    logic              got_q;
    logic              take;

    assign take = beat_fire && !write && (!narrow || (half == h[0]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
        got_q  <= 1'b0;
      end else begin
        if (load) got_q <= 1'b0;
        else if (take) got_q <= 1'b1;
        if (take) word_q <= narrow ? dq_in[HALF_W-1:0] : dq_in[h*HALF_W +: HALF_W];
      end
    end

    assign rd_data[h*HALF_W +: HALF_W] = word_q;
    assign filled[h] = got_q;
  end

  assign rd_valid = done && !write;

  AST_RD_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (&filled)); // R8
  AST_RD_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done); // R8

endmodule

// File: rtl/bus_width_splitter.sv
`timescale 1ns/1ps
module bus_width_splitter #(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic                cfg_narrow,
  input  logic                cfg_big_endian,
  output logic                req_ack,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_valid,
  output logic                ext_req,
  output logic                ext_write,
  output logic [DATA_W-1:0]   ext_dq_out,
  output logic                ext_dq_oe_lo,
  output logic                ext_dq_oe_hi,
  output logic [DATA_W/8-1:0] ext_dqm,
  input  logic [DATA_W-1:0]   ext_dq_in,
  input  logic                ext_ack
);

  localparam int BE_W = DATA_W / 8;

  logic              accept;
  logic              beat_fire;
  logic              last_fire;
  logic              cur_write;
  logic              cur_narrow;
  logic              cur_half;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  bws_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .cfg_narrow     (cfg_narrow),
    .cfg_big_endian (cfg_big_endian),
    .ext_ack        (ext_ack),
    .accept         (accept),
    .ext_req        (ext_req),
    .beat_fire      (beat_fire),
    .last_fire      (last_fire),
    .cur_write      (cur_write),
    .cur_narrow     (cur_narrow),
    .cur_half       (cur_half),
    .req_ack        (req_ack)
  );

  bws_lane_mux #(.DATA_W(DATA_W)) u_lanes (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (ext_req),
    .write  (cur_write),
    .narrow (cur_narrow),
    .half   (cur_half),
    .wdata  (wdata_q),
    .be     (be_q),
    .dq_out (ext_dq_out),
    .dqm    (ext_dqm),
    .oe_lo  (ext_dq_oe_lo),
    .oe_hi  (ext_dq_oe_hi)
  );

  bws_rd_asm #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .beat_fire (beat_fire),
    .write     (cur_write),
    .narrow    (cur_narrow),
    .half      (cur_half),
    .done      (req_ack),
    .dq_in     (ext_dq_in),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  assign ext_write = ext_req && cur_write;

  AST_FINAL_BEAT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> req_ack); // R7
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (!ext_req && !req_ack)); // R10

endmodule

// File: tb/tb_bus_width_splitter.sv
`timescale 1ns/1ps
module tb_bus_width_splitter;

  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic [7:0]    req_be = '0;
  logic          cfg_narrow = 1'b0;
  logic          cfg_big_endian = 1'b0;
  logic          req_ack;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          ext_req;
  logic          ext_write;
  logic [DW-1:0] ext_dq_out;
  logic          ext_dq_oe_lo;
  logic          ext_dq_oe_hi;
  logic [7:0]    ext_dqm;
  logic [DW-1:0] ext_dq_in = '0;
  logic          ext_ack = 1'b0;

  always #2.5 clk = ~clk;

  bus_width_splitter #(.DATA_W(DW)) dut (.*);

  int n_chk = 0;
  int n_fail = 0;

  // core model state
  int            core_delay = 0;
  int            wcnt = 0;
  int            nbeats = 0;
  logic [DW-1:0] rd_words [0:1];
  logic [DW-1:0] log_dq   [0:3];
  logic [7:0]    log_dqm  [0:3];
  logic          log_oelo [0:3];
  logic          log_oehi [0:3];

  // results captured by run_req
  logic          got_ack;
  logic [DW-1:0] ack_rd;
  logic          ack_rv;
  logic          ack_extreq;
  logic          after_ack;

  always @(negedge clk) begin
    if (ext_ack) begin
      ext_ack = 1'b0;
    end else if (ext_req) begin
      if (wcnt >= core_delay) begin
        if (nbeats < 4) begin
          log_dq[nbeats]   = ext_dq_out;
          log_dqm[nbeats]  = ext_dqm;
          log_oelo[nbeats] = ext_dq_oe_lo;
          log_oehi[nbeats] = ext_dq_oe_hi;
          ext_dq_in = rd_words[nbeats < 2 ? nbeats : 1];
        end
        nbeats = nbeats + 1;
        ext_ack = 1'b1;
        wcnt = 0;
      end else begin
        wcnt = wcnt + 1;
      end
    end
  end

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic wr, input logic [DW-1:0] wd, input logic [7:0] be,
                         input logic nar, input logic big, input logic flip, input int dly);
    int cyc;
    @(negedge clk);
    core_delay = dly;
    wcnt = 0;
    nbeats = 0;
    req_write = wr;
    req_wdata = wd;
    req_be = be;
    cfg_narrow = nar;
    cfg_big_endian = big;
    req_valid = 1'b1;
    @(negedge clk);
    if (flip) begin
      cfg_narrow = ~nar;
      cfg_big_endian = ~big;
    end
    cyc = 0;
    while (!req_ack && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    got_ack = req_ack;
    ack_rd = rd_data;
    ack_rv = rd_valid;
    ack_extreq = ext_req;
    req_valid = 1'b0;
    @(negedge clk);
    after_ack = req_ack;
    cfg_narrow = 1'b0;
    cfg_big_endian = 1'b0;
  endtask

  task automatic check_ack(input string tag);
    chk(64'(got_ack), 64'd1, {"R7 ack seen ", tag});
    chk(64'(ack_extreq), 64'd0, {"R7 no beat during ack ", tag});
    chk(64'(after_ack), 64'd0, {"R7 ack single cycle ", tag});
  endtask

  task automatic t_reset;
    chk(64'(ext_req), 64'd0, "R10 ext_req idle");
    chk(64'(req_ack), 64'd0, "R10 req_ack idle");
    chk(64'(rd_valid), 64'd0, "R10 rd_valid idle");
    chk(64'(ext_dqm), 64'hFF, "R10 dqm idle");
    chk(64'({ext_dq_oe_hi, ext_dq_oe_lo}), 64'd0, "R10 oe idle");
  endtask

  task automatic t_wide_write;
    run_req(1'b1, 64'h1122_3344_5566_7788, 8'hA5, 1'b0, 1'b0, 1'b0, 0);
    check_ack("wide wr");
    chk(64'(nbeats), 64'd1, "R1 one beat");
    chk(log_dq[0], 64'h1122_3344_5566_7788, "R1 wide data");
    chk(64'(log_dqm[0]), 64'h5A, "R1 wide mask");
    chk(64'({log_oehi[0], log_oelo[0]}), 64'd3, "R4 write oe");
    chk(64'(ack_rv), 64'd0, "R8 no rd_valid on write");
  endtask

  task automatic t_wide_read;
    rd_words[0] = 64'hDEAD_BEEF_0BAD_F00D;
    rd_words[1] = 64'h0;
    run_req(1'b0, 64'h0, 8'hFF, 1'b0, 1'b1, 1'b0, 2);
    check_ack("wide rd");
    chk(64'(nbeats), 64'd1, "R1 one read beat");
    chk(64'({log_oehi[0], log_oelo[0]}), 64'd0, "R4 read oe released");
    chk(64'(ack_rv), 64'd1, "R8 rd_valid with ack");
    chk(ack_rd, 64'hDEAD_BEEF_0BAD_F00D, "R8 wide read data");
  endtask

  task automatic t_narrow_be_write;
    run_req(1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 8'h3C, 1'b1, 1'b1, 1'b0, 0);
    check_ack("narrow be wr");
    chk(64'(nbeats), 64'd2, "R2 two beats");
    chk(64'(log_dq[0][31:0]), 64'hAAAA_BBBB, "R5 first beat upper word");
    chk(64'(log_dq[1][31:0]), 64'hCCCC_DDDD, "R5 second beat lower word");
    chk(64'(log_dqm[0]), 64'hFC, "R3 mask beat0 upper half");
    chk(64'(log_dqm[1]), 64'hF3, "R3 mask beat1 lower half");
    chk(64'({log_oehi[1], log_oelo[1]}), 64'd3, "R4 narrow write oe");
  endtask

  task automatic t_narrow_le_write;
    run_req(1'b1, 64'h0102_0304_0506_0708, 8'h0F, 1'b1, 1'b0, 1'b0, 1);
    check_ack("narrow le wr");
    chk(64'(nbeats), 64'd2, "R2 two beats with half-only enables");
    chk(64'(log_dq[0][31:0]), 64'h0506_0708, "R6 first beat lower word");
    chk(64'(log_dq[1][31:0]), 64'h0102_0304, "R6 second beat upper word");
    chk(64'(log_dqm[0]), 64'hF0, "R3 mask beat0 lower half");
    chk(64'(log_dqm[1]), 64'hFF, "R3 mask beat1 all disabled");
  endtask

  task automatic t_narrow_be_read;
    rd_words[0] = 64'h5555_5555_1234_5678;
    rd_words[1] = 64'h6666_6666_9ABC_DEF0;
    run_req(1'b0, 64'h0, 8'hFF, 1'b1, 1'b1, 1'b0, 0);
    check_ack("narrow be rd");
    chk(64'(nbeats), 64'd2, "R2 two read beats");
    chk(64'({log_oehi[0], log_oelo[0], log_oehi[1], log_oelo[1]}), 64'd0, "R4 narrow read released");
    chk(64'(log_dqm[0][7:4]), 64'hF, "R3 upper masks on read");
    chk(64'(ack_rv), 64'd1, "R8 rd_valid narrow");
    chk(ack_rd, 64'h1234_5678_9ABC_DEF0, "R8 big-endian assembly");
  endtask

  task automatic t_narrow_le_read;
    rd_words[0] = 64'h7777_7777_CAFE_0001;
    rd_words[1] = 64'h8888_8888_FACE_0002;
    run_req(1'b0, 64'h0, 8'hFF, 1'b1, 1'b0, 1'b0, 3);
    check_ack("narrow le rd");
    chk(ack_rd, 64'hFACE_0002_CAFE_0001, "R8 little-endian assembly");
  endtask

  task automatic t_cfg_flip;
    run_req(1'b1, 64'hF0F0_0000_0F0F_1111, 8'hFF, 1'b1, 1'b0, 1'b1, 1);
    check_ack("cfg flip");
    chk(64'(nbeats), 64'd2, "R9 width held");
    chk(64'(log_dq[0][31:0]), 64'h0F0F_1111, "R9 order held");
    chk(64'(log_dqm[0]), 64'hF0, "R9 narrow mask held");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    rd_words[0] = '0;
    rd_words[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wide_write();
    t_wide_read();
    t_narrow_be_write();
    t_narrow_le_write();
    t_narrow_be_read();
    t_narrow_le_read();
    t_cfg_flip();
    @(negedge clk);
    t_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule